// File: doc/BRIEF.md
# Toggle-Handshake Signed Divider

This unit performs one 32-bit signed integer division per request, for a controller generated as a state machine. The controller does not raise a start strobe. It asks for a division by inverting its request-enable bit, so that the bit no longer matches the acknowledge-enable bit that the unit keeps internally. The unit then needs two clock edges to answer.

On the first edge the unit copies the request bit into its acknowledge bit and raises `done`. On the second edge it writes the signed quotient and remainder of the operands present on its inputs in that cycle, and `done` falls again. The results are therefore valid from the cycle in which `done` returns to 0. The controller keeps its operands stable while `done` is high and reads the results on the following cycle.

Division truncates toward zero, and the remainder takes the sign of the dividend. A zero divisor does not raise an error: it gives a quotient of 0 and returns the dividend as the remainder. Dividing the most negative value by −1 wraps back to the most negative value.

Top module: `toggleDivider`

## Requirements
- R1: While `rst` is high at a clock edge, `ackEn`, `done`, `quotient` and `remainder` all become 0.
- R2: When `ackEn` equals `reqEn` and `done` is 0, an edge changes none of `ackEn`, `done`, `quotient` or `remainder`, whatever the operand inputs do.
- R3: When `ackEn` differs from `reqEn` and `done` is 0, the next edge loads `ackEn` with the value of `reqEn` and sets `done` to 1.
- R4: When `done` is 1, the next edge writes `quotient` and `remainder` and clears `done`, and leaves `ackEn` unchanged. A toggle of `reqEn` made while `done` is 1 is therefore taken only on the edge after `done` has cleared.
- R5: Each toggle of `reqEn` produces exactly one `done` pulse, and each pulse lasts exactly one cycle.
- R6: The quotient is the signed quotient truncated toward zero. The remainder is 0 or has the sign of the dividend, and quotient × divisor + remainder equals the dividend, taken modulo 2^32.
- R7: A divisor of 0 gives a quotient of 0 and a remainder equal to the dividend.
- R8: The most negative dividend (0x80000000) divided by −1 (0xFFFFFFFF) gives a quotient of 0x80000000 and a remainder of 0.
- R9: The results depend only on the `dividend` and `divisor` values present in the cycle in which `done` is 1. Operand values in any other cycle have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqEn | input | 1 | Request bit from the controller; inverting it asks for a division |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Signed divisor |
| quotient | output | 32 | Signed quotient, registered |
| remainder | output | 32 | Signed remainder, registered |
| done | output | 1 | High for one cycle between accepting a request and writing its results |
| ackEn | output | 1 | Acknowledge-enable bit; follows `reqEn` once a request is accepted |

## Verification
The embedded properties check the handshake on every cycle:
- the idle hold;
- the acceptance edge;
- the one-cycle `done` pulse;
- the fact that `ackEn` cannot move while `done` is high;
- the stability of the results outside the write edge;
- the arithmetic identity, the remainder sign and the two special operand cases, each checked against the operands sampled on the write edge.

Only the bench scenarios can show that the values are actually right. The bench compares quotient and remainder against an independent reference model for random and extreme operand pairs. It also shows that operands changed before the write cycle are ignored, that a toggle made during the `done` cycle gives a second, later result, and that the number of `done` pulses matches the number of toggles.

// File: rtl/divPkg.sv
`timescale 1ns/1ps
package divPkg;
  // Strobes passed from the handshake control to the arithmetic datapath.
  typedef struct packed {
    logic accept;    // a request is taken on this edge
    logic writeRes;  // results are written on this edge
  } divStrobe_t;
endpackage

// File: rtl/divCore.sv
`timescale 1ns/1ps
// Combinational signed divide built from a magnitude divide and sign repair.
module divCore #(
  parameter int W = 32
) (
  input  logic [W-1:0] numIn,
  input  logic [W-1:0] denIn,
  output logic [W-1:0] quoOut,
  output logic [W-1:0] remOut
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic          numNeg;
  logic          denNeg;
  logic          denZero;
  logic [W-1:0]  numMag;
  logic [W-1:0]  denMag;
  logic [W-1:0]  denSafe;
  logic [W-1:0]  quoMag;
  logic [W-1:0]  remMag;

  always_comb begin
    numNeg  = numIn[W-1];
    denNeg  = denIn[W-1];
    denZero = (denIn == ZERO);

    // The magnitude of the most negative value, 2^(W-1), still fits in W unsigned bits.
    numMag  = numNeg ? (ZERO - numIn) : numIn;
    denMag  = denNeg ? (ZERO - denIn) : denIn;

    // Divide by 1 instead of 0 so the unsigned divider never sees a zero divisor.
    denSafe = denZero ? ONE : denMag;
    quoMag  = numMag / denSafe;
    remMag  = numMag % denSafe;

    if (denZero) begin
      quoOut = ZERO;
      remOut = numIn;
    end else begin
      quoOut = (numNeg ^ denNeg) ? (ZERO - quoMag) : quoMag;
      remOut = numNeg ? (ZERO - remMag) : remMag;
    end
  end
endmodule

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
// Toggle handshake: a request is pending while ackEn differs from reqEn.
module divCtrl
  import divPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqEn,
  output logic       ackEn,
  output logic       done,
  output divStrobe_t strobe
);
  logic ackQ;
  logic doneQ;

  always_comb begin
    strobe.accept   = !doneQ && (ackQ != reqEn);
    strobe.writeRes = doneQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ  <= 1'b0;
      doneQ <= 1'b0;
    end else if (strobe.accept) begin
      ackQ  <= reqEn;
      doneQ <= 1'b1;
    end else if (strobe.writeRes) begin
      doneQ <= 1'b0;
    end
  end

  assign ackEn = ackQ;
  assign done  = doneQ;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!ackEn && !done));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ackEn == reqEn && !done) |=> ($stable(ackEn) && !done));

  // R3
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ackEn != reqEn && !done) |=> (done && ackEn == $past(reqEn)));

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(ackEn));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/divData.sv
`timescale 1ns/1ps
// Result registers. They load only on the write strobe, from the operands of that cycle.
module divData
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  divStrobe_t   strobe,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] NEG_ONE = '1;

  logic [W-1:0] quoNext;
  logic [W-1:0] remNext;

  divCore #(.W(W)) uCore (
    .numIn (dividend),
    .denIn (divisor),
    .quoOut(quoNext),
    .remOut(remNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient  <= '0;
      remainder <= '0;
    end else if (strobe.writeRes) begin
      quotient  <= quoNext;
      remainder <= remNext;
    end
  end

  // R1
  reset_result_chk: assert property (@(posedge clk) rst |=> (quotient == '0 && remainder == '0));

  // R2 R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.writeRes |=> ($stable(quotient) && $stable(remainder)));

  // R6
  div_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.writeRes && divisor != '0) |=>
      ((quotient * $past(divisor) + remainder) == $past(dividend)));

  // R6
  rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.writeRes && divisor != '0) |=>
      (remainder == '0 || remainder[W-1] == $past(dividend[W-1])));

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.writeRes && divisor == '0) |=>
      (quotient == '0 && remainder == $past(dividend)));

  // R8
  min_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.writeRes && dividend == MIN_VAL && divisor == NEG_ONE) |=>
      (quotient == MIN_VAL && remainder == '0));
endmodule

// File: rtl/toggleDivider.sv
`timescale 1ns/1ps
module toggleDivider
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqEn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         ackEn
);
  divStrobe_t strobe;

  divCtrl uCtrl (
    .clk   (clk),
    .rst   (rst),
    .reqEn (reqEn),
    .ackEn (ackEn),
    .done  (done),
    .strobe(strobe)
  );

  divData #(.W(W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder)
  );
endmodule

// File: tb/tb_toggleDivider.sv
`timescale 1ns/1ps
module tb_toggleDivider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqEn = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] quotient;
  logic [31:0] remainder;
  logic        done;
  logic        ackEn;

  int tests = 0;
  int fails = 0;
  int toggles = 0;
  int pulses = 0;
  int doubleHigh = 0;
  logic prevDone = 1'b0;

  always #10 clk = ~clk;

  toggleDivider dut (
    .clk(clk), .rst(rst), .reqEn(reqEn), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .ackEn(ackEn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: signed division truncating toward zero, with the two special cases.
  task automatic refDiv(input logic signed [31:0] a, input logic signed [31:0] b,
                        output logic [31:0] q, output logic [31:0] r);
    if (b == 0) begin
      q = 32'h0; r = a;
    end else if (a == 32'sh8000_0000 && b == -32'sd1) begin
      q = 32'h8000_0000; r = 32'h0;
    end else begin
      q = a / b; r = a % b;
    end
  endtask

  // Counts done pulses and flags any pulse longer than one cycle (R5).
  always @(negedge clk) begin
    if (!rst) begin
      if (done) pulses++;
      if (done && prevDone) doubleHigh++;
      prevDone = done;
    end else begin
      prevDone = 1'b0;
    end
  end

  task automatic runDiv(input logic [31:0] a, input logic [31:0] b, input string tag,
                        input bit junkFirst, input bit toggleInDone);
    logic [31:0] eq;
    logic [31:0] er;
    refDiv(a, b, eq, er);
    @(negedge clk);
    dividend = junkFirst ? (a ^ 32'h5A5A_1234) : a;
    divisor  = junkFirst ? (b + 32'd7) : b;
    reqEn = ~reqEn; toggles++;
    @(negedge clk);
    chk(done == 1'b1, "R3 done set after toggle", {31'b0, done}, 32'd1);
    chk(ackEn == reqEn, "R3 ackEn follows reqEn", {31'b0, ackEn}, {31'b0, reqEn});
    dividend = a; divisor = b;
    if (toggleInDone) begin
      reqEn = ~reqEn; toggles++;
    end
    @(negedge clk);
    chk(done == 1'b0, "R4 done clears after write", {31'b0, done}, 32'd0);
    chk(quotient == eq, {tag, " quotient"}, quotient, eq);
    chk(remainder == er, {tag, " remainder"}, remainder, er);
    if (toggleInDone) begin
      chk(ackEn != reqEn, "R4 toggle during done not yet taken", {31'b0, ackEn}, {31'b0, ~reqEn});
      @(negedge clk);
      chk(done == 1'b1, "R4 held toggle accepted after done clears", {31'b0, done}, 32'd1);
      chk(ackEn == reqEn, "R4 ackEn follows late toggle", {31'b0, ackEn}, {31'b0, reqEn});
      @(negedge clk);
      chk(done == 1'b0, "R5 second pulse ends", {31'b0, done}, 32'd0);
      chk(quotient == eq, "R4 second result quotient", quotient, eq);
    end
  endtask

  // R2: with no pending request, nothing moves even when the operands change.
  task automatic idleCheck(input int n);
    logic [31:0] q0;
    logic [31:0] r0;
    logic        a0;
    q0 = quotient; r0 = remainder; a0 = ackEn;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dividend = $urandom; divisor = $urandom;
    end
    @(negedge clk);
    chk(quotient == q0, "R2 idle quotient holds", quotient, q0);
    chk(remainder == r0, "R2 idle remainder holds", remainder, r0);
    chk(done == 1'b0, "R2 idle done low", {31'b0, done}, 32'd0);
    chk(ackEn == a0, "R2 idle ackEn holds", {31'b0, ackEn}, {31'b0, a0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    dividend = 32'hDEAD_BEEF; divisor = 32'h3;
    repeat (3) @(negedge clk);
    // R1: outputs are cleared while reset is held.
    chk(quotient == 0, "R1 reset quotient", quotient, 32'd0);
    chk(remainder == 0, "R1 reset remainder", remainder, 32'd0);
    chk(done == 0, "R1 reset done", {31'b0, done}, 32'd0);
    chk(ackEn == 0, "R1 reset ackEn", {31'b0, ackEn}, 32'd0);
    rst = 1'b0;
    idleCheck(3);

    // Directed corner cases.
    runDiv(32'd100, 32'd7, "R6 pos/pos", 1'b0, 1'b0);
    runDiv(-32'sd100, 32'd7, "R6 neg/pos", 1'b0, 1'b0);
    runDiv(32'd100, -32'sd7, "R6 pos/neg", 1'b0, 1'b0);
    runDiv(-32'sd100, -32'sd7, "R6 neg/neg", 1'b0, 1'b0);
    runDiv(32'd5, 32'd0, "R7 divide by zero", 1'b0, 1'b0);
    runDiv(-32'sd9, 32'd0, "R7 negative divide by zero", 1'b0, 1'b0);
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, "R8 min over minus one", 1'b0, 1'b0);
    runDiv(32'h8000_0000, 32'd1, "R6 min over one", 1'b0, 1'b0);
    runDiv(32'h7FFF_FFFF, 32'h8000_0000, "R6 max over min", 1'b0, 1'b0);
    runDiv(32'h0, -32'sd3, "R6 zero dividend", 1'b0, 1'b0);
    runDiv(32'd1234567, 32'd89, "R9 operands changed before write", 1'b1, 1'b0);
    runDiv(-32'sd77, 32'd5, "R4 toggle during done", 1'b0, 1'b1);
    idleCheck(4);

    // Random operand pairs, with occasional operand changes and double toggles.
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom;
      b = $urandom;
      case ($urandom % 4)
        0: b = b % 32'd17;
        1: b = -(b % 32'd17);
        default: ;
      endcase
      runDiv(a, b, "R6 random", ($urandom % 3) == 0, ($urandom % 8) == 0);
    end

    runDiv(32'd100, 32'd7, "R6 final", 1'b0, 1'b0);
    @(negedge clk);
    chk(doubleHigh == 0, "R5 done never high two cycles", doubleHigh, 32'd0);
    chk(pulses == toggles, "R5 one pulse per toggle", pulses, toggles);

    // R1: a reset after activity clears the results again.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(quotient == 0, "R1 reset clears quotient", quotient, 32'd0);
    chk(remainder == 0, "R1 reset clears remainder", remainder, 32'd0);
    chk(ackEn == 0, "R1 reset clears ackEn", {31'b0, ackEn}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule